// File: doc/BRIEF.md
# Bridge Status, Interrupt and Lock Registers

This block holds the control and status registers a bus bridge exposes at its local side. Hardware event pulses from the PCI engine, the DMA channels, the mailbox and the inbound queue set sticky status flags. Software reads and clears those flags through a simple halfword register port. A mask selects which local flags drive the single interrupt line. A system control register drives the downstream bus reset and is guarded by a write lock. Only a magic key value removes the lock.

Two status registers use different clearing rules. Software clears the PCI error flags by writing back the value it read, because they are write-one-to-clear. In the local interrupt status byte, any bit written as zero is cleared, so writing all zeros clears every pending flag. A hardware event always takes priority over a software clear that arrives in the same clock cycle.

Top module: `bridge_stat_regs`

## Requirements
- R1: After reset, all status flags and the mask read zero. The system register reads 0x4000, which means locked with the bus held in reset. The interrupt output is low and the bus reset output is low.
- R2: Index 0 holds the PCI error flags in bits 15:12. Event input bit 3 sets bit 15 (parity), bit 2 sets bit 14 (system error), bit 1 sets bit 13 (master abort) and bit 0 sets bit 12 (target abort). A flag stays set until software clears it.
- R3: A write to index 0 with strobe 1 set clears each error flag whose data bit is one. A zero data bit, or a write with strobe 1 clear, leaves the flag unchanged.
- R4: Bits 7:0 of index 1 are the local pending flags. Event bit i sets flag i: 7 mailbox, 6 read abort, 5 write abort, 4 pin interrupt, 3 parity, 2 queue post, 1 DMA 1, 0 DMA 0.
- R5: A write to index 1 with strobe 0 set clears each pending flag whose data bit is zero and keeps each flag whose data bit is one. Writing 0x00 clears all of them.
- R6: Bits 15:8 of index 1 are the mask, written under strobe 1. The interrupt output is high one cycle after some pending flag has its mask bit set, and low one cycle after none does.
- R7: When an event and a software clear hit the same flag in the same cycle, the flag is set afterwards.
- R8: Index 2 is the 16-bit system register. The bus reset output (active low) always equals its bit 15.
- R9: While bit 14 (lock) is set, a write is ignored unless both strobes are set and the data is 0xA05F. That write clears only bit 14.
- R10: While unlocked, strobe 0 writes bits 7:0 and strobe 1 writes bits 15:8 of the system register. Writing bit 14 as one locks it again.
- R11: Unused bits and indexes with no register read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Halfword register index |
| reg_wr | input | 1 | Write enable |
| reg_be | input | 2 | Byte strobes (bit 0 = bits 7:0) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| pci_err_evt | input | N_PCI_ERR | PCI error event pulses |
| lb_evt | input | N_LB_EVT | Local interrupt event pulses |
| irq | output | 1 | Masked interrupt request |
| bus_rst_n | output | 1 | Downstream bus reset, active low |

## Verification
The bench builds the block with its default parameters: four PCI error flags at bits 15:12, eight local event lines, the registered interrupt variant and the key 0xA05F. These values make every lane and bit layout in the requirements observable at the ports. They also expose the one-cycle interrupt lag.

Directed sequences cover the following cases:
- partial clears under each clearing rule;
- writes with the wrong strobe;
- event and clear collisions;
- a key sent with only one strobe;
- re-locking.

Pseudo-random traffic then mixes events, keys and writes against the reference model on every cycle.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
   localparam int SYS_W        = 16;
   localparam int DATA_W       = 16;
   localparam int SYS_LOCK_BIT = 14;
   localparam int SYS_RUN_BIT  = 15;
   localparam logic [SYS_W-1:0] SYS_RST_VAL = 16'h4000;
   localparam int IDX_PCI_ERR  = 0;
   localparam int IDX_LB_IRQ   = 1;
   localparam int IDX_SYS      = 2;
   localparam int MASK_LSB     = 8;
endpackage

// File: rtl/bsr_w1c_bank.sv
module bsr_w1c_bank #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_en,
   input  logic [N-1:0] clr_bits,
   input  logic [N-1:0] set_bits,
   output logic [N-1:0] stat
);
   logic [N-1:0] stat_d;

   always_comb begin
      stat_d = stat;
      if (clr_en) stat_d = stat_d & ~clr_bits;
      stat_d = stat_d | set_bits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat <= '0;
      else        stat <= stat_d;
   end

   a_r7_err_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_bits != '0) |=> ((stat & $past(set_bits)) == $past(set_bits)));

   a_r2_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_en && set_bits == '0) |=> $stable(stat));

   a_r3_w1c_only_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && set_bits == '0) |=> ((stat & ~$past(stat)) == '0));
endmodule

// File: rtl/bsr_irq_bank.sv
module bsr_irq_bank #(
   parameter int N       = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pend_wr,
   input  logic [N-1:0] pend_keep,
   input  logic         mask_wr,
   input  logic [N-1:0] mask_d,
   input  logic [N-1:0] evt,
   output logic [N-1:0] pend,
   output logic [N-1:0] mask,
   output logic         irq
);
   logic [N-1:0] pend_d;
   logic         irq_raw;

   always_comb begin
      pend_d = pend;
      if (pend_wr) pend_d = pend_d & pend_keep;
      pend_d = pend_d | evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= '0;
         mask <= '0;
      end else begin
         pend <= pend_d;
         if (mask_wr) mask <= mask_d;
      end
   end

   assign irq_raw = |(pend & mask);

   generate
      if (REG_OUT) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_raw;
         end
         assign irq = irq_q;

         a_r6_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            ((pend & mask) != '0) |=> irq);
         a_r6_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
            ((pend & mask) == '0) |=> !irq);
      end else begin : g_irq_comb
         assign irq = irq_raw;
      end
   endgenerate

   a_r7_lb_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((pend & $past(evt)) == $past(evt)));

   a_r5_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_wr && evt == '0) |=> $stable(pend));
endmodule

// File: rtl/bsr_sysctl.sv
module bsr_sysctl
   import bsr_pkg::*;
#(
   parameter logic [SYS_W-1:0] KEY = 16'hA05F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [1:0]       be,
   input  logic [SYS_W-1:0] wdata,
   output logic [SYS_W-1:0] sys
);
   logic locked;
   logic key_hit;

   assign locked  = sys[SYS_LOCK_BIT];
   assign key_hit = wr && (be == 2'b11) && (wdata == KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sys <= SYS_RST_VAL;
      end else if (locked) begin
         if (key_hit) sys[SYS_LOCK_BIT] <= 1'b0;
      end else if (wr) begin
         if (be[0]) sys[7:0]  <= wdata[7:0];
         if (be[1]) sys[15:8] <= wdata[15:8];
      end
   end

   a_r9_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !(wr && be == 2'b11 && wdata == KEY)) |=> $stable(sys));

   a_r9_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && wr && be == 2'b11 && wdata == KEY)
      |=> (!sys[SYS_LOCK_BIT] && sys[SYS_RUN_BIT] == $past(sys[SYS_RUN_BIT])));

   a_r10_relock: assert property (@(posedge clk) disable iff (!rst_n)
      (!locked && wr && be[1] && wdata[SYS_LOCK_BIT]) |=> sys[SYS_LOCK_BIT]);
endmodule

// File: rtl/bridge_stat_regs.sv
module bridge_stat_regs
   import bsr_pkg::*;
#(
   parameter int               ADDR_W         = 3,
   parameter int               N_PCI_ERR      = 4,
   parameter int               PCI_ERR_LSB    = 12,
   parameter int               N_LB_EVT       = 8,
   parameter bit               IRQ_REGISTERED = 1'b1,
   parameter logic [SYS_W-1:0] UNLOCK_KEY     = 16'hA05F
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic                 reg_wr,
   input  logic [1:0]           reg_be,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   input  logic [N_PCI_ERR-1:0] pci_err_evt,
   input  logic [N_LB_EVT-1:0]  lb_evt,
   output logic                 irq,
   output logic                 bus_rst_n
);
   localparam int PCI_ERR_MSB = PCI_ERR_LSB + N_PCI_ERR - 1;

   generate
      if (ADDR_W < 2)
         $error("ADDR_W must cover three register indexes");
      if (PCI_ERR_LSB < 8 || PCI_ERR_MSB > 15)
         $error("PCI error flags must sit inside byte lane 1");
      if (N_LB_EVT < 1 || N_LB_EVT > 8)
         $error("local events must fit in one byte lane");
   endgenerate

   logic                 sel_err, sel_irq, sel_sys;
   logic [N_PCI_ERR-1:0] err_stat;
   logic [N_LB_EVT-1:0]  lb_pend, lb_mask;
   logic [SYS_W-1:0]     sys;

   assign sel_err = (reg_addr == ADDR_W'(IDX_PCI_ERR));
   assign sel_irq = (reg_addr == ADDR_W'(IDX_LB_IRQ));
   assign sel_sys = (reg_addr == ADDR_W'(IDX_SYS));

   bsr_w1c_bank #(.N(N_PCI_ERR)) u_err (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_en   (reg_wr && sel_err && reg_be[1]),
      .clr_bits (reg_wdata[PCI_ERR_LSB +: N_PCI_ERR]),
      .set_bits (pci_err_evt),
      .stat     (err_stat)
   );

   bsr_irq_bank #(.N(N_LB_EVT), .REG_OUT(IRQ_REGISTERED)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .pend_wr   (reg_wr && sel_irq && reg_be[0]),
      .pend_keep (reg_wdata[N_LB_EVT-1:0]),
      .mask_wr   (reg_wr && sel_irq && reg_be[1]),
      .mask_d    (reg_wdata[MASK_LSB +: N_LB_EVT]),
      .evt       (lb_evt),
      .pend      (lb_pend),
      .mask      (lb_mask),
      .irq       (irq)
   );

   bsr_sysctl #(.KEY(UNLOCK_KEY)) u_sys (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_wr && sel_sys),
      .be    (reg_be),
      .wdata (reg_wdata),
      .sys   (sys)
   );

   assign bus_rst_n = sys[SYS_RUN_BIT];

   always_comb begin
      reg_rdata = '0;
      if (sel_err) reg_rdata[PCI_ERR_LSB +: N_PCI_ERR] = err_stat;
      if (sel_irq) begin
         reg_rdata[N_LB_EVT-1:0]        = lb_pend;
         reg_rdata[MASK_LSB +: N_LB_EVT] = lb_mask;
      end
      if (sel_sys) reg_rdata = sys;
   end

   a_r8_bus_reset_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_rst_n) |-> ($past(reg_wr) && $past(sel_sys)));
endmodule

// File: tb/bridge_stat_regs_tb.sv
`timescale 1ns/1ps
module bridge_stat_regs_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_be = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [3:0]  pci_err_evt = '0;
   logic [7:0]  lb_evt = '0;
   logic        irq;
   logic        bus_rst_n;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   bridge_stat_regs u_dut (
      .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_wr (reg_wr),
      .reg_be (reg_be), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .pci_err_evt (pci_err_evt), .lb_evt (lb_evt), .irq (irq),
      .bus_rst_n (bus_rst_n)
   );

   // behavioural reference model
   logic [3:0]  m_err;
   logic [7:0]  m_pend, m_mask;
   logic [15:0] m_sys;
   logic        m_irq;

   always @(posedge clk) begin
      logic nirq;
      if (!rst_n) begin
         m_err = '0; m_pend = '0; m_mask = '0; m_sys = 16'h4000; m_irq = 1'b0;
      end else begin
         nirq = (m_pend & m_mask) != 8'h00;
         if (reg_wr && reg_addr == 3'd0 && reg_be[1]) m_err = m_err & ~reg_wdata[15:12];
         m_err = m_err | pci_err_evt;
         if (reg_wr && reg_addr == 3'd1 && reg_be[0]) m_pend = m_pend & reg_wdata[7:0];
         m_pend = m_pend | lb_evt;
         if (reg_wr && reg_addr == 3'd1 && reg_be[1]) m_mask = reg_wdata[15:8];
         if (reg_wr && reg_addr == 3'd2) begin
            if (m_sys[14]) begin
               if (reg_be == 2'b11 && reg_wdata == 16'hA05F) m_sys[14] = 1'b0;
            end else begin
               if (reg_be[0]) m_sys[7:0]  = reg_wdata[7:0];
               if (reg_be[1]) m_sys[15:8] = reg_wdata[15:8];
            end
         end
         m_irq = nirq;
      end
   end

   function automatic logic [15:0] exp_rd(input logic [2:0] a);
      case (a)
         3'd0: return {m_err, 12'h000};
         3'd1: return {m_mask, m_pend};
         3'd2: return m_sys;
         default: return 16'h0000;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         string rq;
         case (reg_addr)
            3'd0: rq = "R2 R3";
            3'd1: rq = "R4 R5";
            3'd2: rq = "R9 R10";
            default: rq = "R11";
         endcase
         chk(reg_rdata === exp_rd(reg_addr), rq, reg_rdata, exp_rd(reg_addr));
         chk(irq === m_irq, "R6 irq", {15'h0, irq}, {15'h0, m_irq});
         chk(bus_rst_n === m_sys[15], "R8 bus_rst_n", {15'h0, bus_rst_n}, {15'h0, m_sys[15]});
      end
   end

   task automatic drive(input logic [2:0] a, input logic w, input logic [1:0] be,
                        input logic [15:0] d, input logic [3:0] pe, input logic [7:0] le);
      @(posedge clk); #5;
      reg_addr = a; reg_wr = w; reg_be = be; reg_wdata = d; pci_err_evt = pe; lb_evt = le;
   endtask

   task automatic rd_expect(input logic [2:0] a, input logic [15:0] exp, input string req);
      drive(a, 1'b0, 2'b00, 16'h0, 4'h0, 8'h00);
      @(negedge clk); #1;
      chk(reg_rdata === exp, req, reg_rdata, exp);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #5 rst_n = 1'b1;
      // R1 reset state
      rd_expect(3'd0, 16'h0000, "R1 err");
      rd_expect(3'd1, 16'h0000, "R1 irq reg");
      rd_expect(3'd2, 16'h4000, "R1 sys");
      chk(bus_rst_n === 1'b0, "R1 bus_rst_n", {15'h0, bus_rst_n}, 16'h0);
      chk(irq === 1'b0, "R1 irq", {15'h0, irq}, 16'h0);
      rd_expect(3'd5, 16'h0000, "R11 unmapped");
      // R2 event mapping
      drive(3'd0, 1'b0, 2'b00, 16'h0, 4'b1000, 8'h00);
      rd_expect(3'd0, 16'h8000, "R2 parity");
      drive(3'd0, 1'b0, 2'b00, 16'h0, 4'b0011, 8'h00);
      rd_expect(3'd0, 16'hB000, "R2 aborts");
      // R3 w1c
      drive(3'd0, 1'b1, 2'b01, 16'hF000, 4'h0, 8'h00);
      rd_expect(3'd0, 16'hB000, "R3 wrong strobe");
      drive(3'd0, 1'b1, 2'b10, 16'h3000, 4'h0, 8'h00);
      rd_expect(3'd0, 16'h8000, "R3 partial clear");
      // R7 collision on error flag
      drive(3'd0, 1'b1, 2'b10, 16'h8000, 4'b1000, 8'h00);
      rd_expect(3'd0, 16'h8000, "R7 err collision");
      // R4 local events
      drive(3'd1, 1'b0, 2'b00, 16'h0, 4'h0, 8'hA5);
      rd_expect(3'd1, 16'h00A5, "R4 pend");
      // R5 write-zero clear
      drive(3'd1, 1'b1, 2'b01, 16'h00F0, 4'h0, 8'h00);
      rd_expect(3'd1, 16'h00A0, "R5 partial");
      drive(3'd1, 1'b1, 2'b01, 16'h0000, 4'h0, 8'h00);
      rd_expect(3'd1, 16'h0000, "R5 clear all");
      // R6 mask and irq
      drive(3'd1, 1'b1, 2'b10, 16'h0400, 4'h0, 8'h01);
      rd_expect(3'd1, 16'h0401, "R6 mask write");
      @(negedge clk); chk(irq === 1'b0, "R6 unmasked", {15'h0, irq}, 16'h0);
      drive(3'd1, 1'b0, 2'b00, 16'h0, 4'h0, 8'h04);
      drive(3'd1, 1'b0, 2'b00, 16'h0, 4'h0, 8'h00);
      drive(3'd1, 1'b0, 2'b00, 16'h0, 4'h0, 8'h00);
      @(negedge clk); chk(irq === 1'b1, "R6 masked pending", {15'h0, irq}, 16'h1);
      // R7 collision on local flag
      drive(3'd1, 1'b1, 2'b01, 16'h0000, 4'h0, 8'h04);
      rd_expect(3'd1, 16'h0404, "R7 lb collision");
      drive(3'd1, 1'b1, 2'b01, 16'h0000, 4'h0, 8'h00);
      drive(3'd1, 1'b0, 2'b00, 16'h0, 4'h0, 8'h00);
      drive(3'd1, 1'b0, 2'b00, 16'h0, 4'h0, 8'h00);
      @(negedge clk); chk(irq === 1'b0, "R6 irq drops", {15'h0, irq}, 16'h0);
      // R9 lock
      drive(3'd2, 1'b1, 2'b11, 16'h8000, 4'h0, 8'h00);
      rd_expect(3'd2, 16'h4000, "R9 locked ignore");
      chk(bus_rst_n === 1'b0, "R9 bus still reset", {15'h0, bus_rst_n}, 16'h0);
      drive(3'd2, 1'b1, 2'b01, 16'hA05F, 4'h0, 8'h00);
      rd_expect(3'd2, 16'h4000, "R9 half key");
      drive(3'd2, 1'b1, 2'b11, 16'hA05F, 4'h0, 8'h00);
      rd_expect(3'd2, 16'h0000, "R9 key unlock");
      // R10 / R8 unlocked writes
      drive(3'd2, 1'b1, 2'b10, 16'h8012, 4'h0, 8'h00);
      rd_expect(3'd2, 16'h8000, "R10 upper lane");
      chk(bus_rst_n === 1'b1, "R8 release", {15'h0, bus_rst_n}, 16'h1);
      drive(3'd2, 1'b1, 2'b11, 16'hC03C, 4'h0, 8'h00);
      rd_expect(3'd2, 16'hC03C, "R10 relock");
      drive(3'd2, 1'b1, 2'b11, 16'h0000, 4'h0, 8'h00);
      rd_expect(3'd2, 16'hC03C, "R9 relocked ignore");
      // mixed traffic against the model
      for (int i = 0; i < 600; i++) begin
         logic [15:0] d;
         logic [2:0]  a;
         d = 16'($urandom);
         a = 3'($urandom_range(0, 3));
         if ($urandom_range(0, 7) == 0) d = 16'hA05F;
         drive(a, 1'($urandom), 2'($urandom), d,
               ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0,
               ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00);
      end
      drive(3'd0, 1'b0, 2'b00, 16'h0, 4'h0, 8'h00);
      @(negedge clk);
      #2;
      finish_run();
   end
endmodule